// File: doc/BRIEF.md
# Dual-Edge DDR Command Capture and Bank Tracker

This block sits behind the command pins of a DDR-style memory model. Each command takes one clock cycle and is carried on a 10-bit command/address bus. One half is driven for the rising clock edge and the other half for the falling edge. The clock-enable pin, sampled on the rising edge, is part of the command. The block joins the two halves into one word and decodes it through a simplified opcode map. Decoded commands are Activate, Read, Write, Precharge, mode-register write, mode-register read, power-down entry and power-down exit.

The block holds an open-row record for each of eight banks. A Read or Write is accepted only while its bank holds an open row. An Activate is accepted only while its bank is closed. An illegal command is dropped and raises a one-cycle error flag. Accepted commands come out as a one-cycle strobe with an operation code and the bank, row and column fields. A Read or Write reports the row that is open in its bank. A small set of mode registers answers mode-register reads. One of these registers is read-only and holds a fixed identity value.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: A synchronous active-high reset closes all banks and empties the capture pipeline, so a Read issued right after reset is refused with an error.
- R2: The CA value at a rising edge forms the upper ten bits of the command word and the value at the following falling edge forms the lower ten. The decoded result appears on the outputs after the next rising edge.
- R3: The three top bits of the upper half select the operation: 0 no-op, 1 Activate, 2 Read, 3 Write, 4 Precharge, 5 mode write, 6 mode read, 7 reserved. Upper-half bits 6:4 carry the bank. Output operation codes are 1 Activate, 2 Read, 3 Write, 4 Precharge, 5 mode write, 6 mode read, 8 power-down entry, 9 power-down exit.
- R4: An Activate to a closed bank opens the bank and strobes the row {upper[3:0], lower[9:0]}. An Activate to an already open bank is dropped with an error.
- R5: A Read or Write to an open bank strobes the bank, the column {lower[9:1], 0} (the least significant column bit is always zero) and the row that is open in that bank.
- R6: A Read or Write to a closed bank gives an error pulse of one cycle, no strobe and no change to any bank.
- R7: A Precharge closes its bank. With upper bit 3 set, it closes all banks.
- R8: When clock-enable goes from high to low, the block strobes power-down entry. When it goes from low to high, the block strobes power-down exit. The CA bits are ignored in both of those cycles and in every cycle while clock-enable stays low. Bank state is kept through power-down.
- R9: A mode write to address 1, 2 or 3 (upper bits 6:0) stores lower[7:0]. A later mode read of that address returns the stored value on the mode-data output.
- R10: Address 0 always reads 0x5A. Addresses of 4 and above read 0. A mode write to any of these addresses changes nothing.
- R11: No-op and reserved codes produce neither a strobe nor an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; CA is captured on both edges |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable, sampled on the rising edge |
| ca | input | 10 | Command/address bus |
| cmd_vld | output | 1 | One-cycle strobe for an accepted command |
| cmd_op | output | 4 | Operation code of the strobed command |
| cmd_bank | output | 3 | Bank field |
| cmd_row | output | 14 | Row of an Activate, or the open row for a Read or Write |
| cmd_col | output | 10 | Start column of a Read or Write |
| cmd_mrd | output | 8 | Mode-register data returned by a mode read |
| seq_err | output | 1 | One-cycle pulse when an illegal command is dropped |

## Verification
Directed sequences put distinct bit patterns in the two bus halves, so a swapped or misaligned half shows up as a wrong row or column. They also drive an all-ones low half to show that column bit 0 is forced to zero. Further sequences issue Read, Write and Activate to open and to closed banks, and issue back-to-back illegal commands. Single and all-bank Precharge show that closing works per bank and globally. A power-down stretch carries valid-looking opcodes to show that they are ignored and that open rows survive. A long pseudo-random run, with a reset in the middle, mixes every opcode with clock-enable drops against the reference model.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;

    parameter int CA_W      = 10;
    parameter int OP_W      = 3;
    parameter int NUM_BANKS = 8;
    parameter int BANK_W    = $clog2(NUM_BANKS);
    parameter int OP_LSB    = CA_W - OP_W;
    parameter int BANK_LSB  = OP_LSB - BANK_W;
    parameter int ROW_W     = BANK_LSB + CA_W;
    parameter int COL_W     = CA_W;
    parameter int MR_AW     = OP_LSB;
    parameter int MR_DW     = 8;
    parameter int MR_NUM    = 4;
    parameter logic [MR_DW-1:0] MR_ID = 8'h5A;

    typedef enum logic [OP_W-1:0] {
        BUS_NOP = 3'd0,
        BUS_ACT = 3'd1,
        BUS_RD  = 3'd2,
        BUS_WR  = 3'd3,
        BUS_PRE = 3'd4,
        BUS_MRW = 3'd5,
        BUS_MRR = 3'd6,
        BUS_RSV = 3'd7
    } bus_op_e;

    typedef enum logic [3:0] {
        CMD_NONE = 4'd0,
        CMD_ACT  = 4'd1,
        CMD_RD   = 4'd2,
        CMD_WR   = 4'd3,
        CMD_PRE  = 4'd4,
        CMD_MRW  = 4'd5,
        CMD_MRR  = 4'd6,
        CMD_PDE  = 4'd8,
        CMD_PDX  = 4'd9
    } cmd_e;

    typedef struct packed {
        logic [CA_W-1:0] rise;
        logic [CA_W-1:0] fall;
        logic            cke;
        logic            cke_prev;
        logic            live;
    } cap_t;

    typedef struct packed {
        cmd_e              op;
        logic [BANK_W-1:0] bank;
        logic              all;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [MR_AW-1:0]  ma;
        logic [MR_DW-1:0]  md;
    } dec_t;

    function automatic dec_t decode_word(input cap_t c);
        dec_t d;
        d.op   = CMD_NONE;
        d.bank = c.rise[OP_LSB-1:BANK_LSB];
        d.all  = c.rise[BANK_LSB-1];
        d.row  = {c.rise[BANK_LSB-1:0], c.fall};
        d.col  = {c.fall[CA_W-1:1], 1'b0};
        d.ma   = c.rise[OP_LSB-1:0];
        d.md   = c.fall[MR_DW-1:0];
        if (c.live) begin
            if (c.cke_prev && !c.cke) begin
                d.op = CMD_PDE;
            end else if (!c.cke_prev && c.cke) begin
                d.op = CMD_PDX;
            end else if (c.cke) begin
                case (bus_op_e'(c.rise[CA_W-1:OP_LSB]))
                    BUS_ACT: d.op = CMD_ACT;
                    BUS_RD:  d.op = CMD_RD;
                    BUS_WR:  d.op = CMD_WR;
                    BUS_PRE: d.op = CMD_PRE;
                    BUS_MRW: d.op = CMD_MRW;
                    BUS_MRR: d.op = CMD_MRR;
                    default: d.op = CMD_NONE;
                endcase
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/ca_capture.sv
module ca_capture
    import ddr_cmd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cke,
    input  logic [CA_W-1:0] ca,
    output cap_t            cap
);
    logic [CA_W-1:0] rise_q;
    logic [CA_W-1:0] fall_q;
    logic            cke_q;
    logic            ckep_q;
    logic            live_q;

    // Upper half and clock enable: rising edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            rise_q <= '0;
            cke_q  <= 1'b1;
            ckep_q <= 1'b1;
            live_q <= 1'b0;
        end else begin
            rise_q <= ca;
            cke_q  <= cke;
            ckep_q <= cke_q;
            live_q <= 1'b1;
        end
    end

    // Lower half: the falling edge inside the same command cycle.
    always_ff @(negedge clk) begin
        fall_q <= ca;
    end

    assign cap = '{rise: rise_q, fall: fall_q, cke: cke_q,
                   cke_prev: ckep_q, live: live_q};

endmodule

// File: rtl/bank_table.sv
module bank_table
    import ddr_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              op,
    input  logic [BANK_W-1:0] bank,
    input  logic              all,
    input  logic [ROW_W-1:0]  row,
    output logic              q_open,
    output logic [ROW_W-1:0]  q_row
);
    logic             open_q [NUM_BANKS];
    logic [ROW_W-1:0] row_q  [NUM_BANKS];
    logic [NUM_BANKS-1:0] open_vec;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                open_q[g] <= 1'b0;
                row_q[g]  <= '0;
            end else if (op == CMD_ACT && int'(bank) == g) begin
                open_q[g] <= 1'b1;
                row_q[g]  <= row;
            end else if (op == CMD_PRE && (all || int'(bank) == g)) begin
                open_q[g] <= 1'b0;
            end
        end
    end

    always_comb begin
        q_open = 1'b0;
        q_row  = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            open_vec[i] = open_q[i];
            if (int'(bank) == i) begin
                q_open = open_q[i];
                q_row  = row_q[i];
            end
        end
    end

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
        (op == CMD_ACT) |=> open_vec[$past(bank)]); // R4

    AST_PRE_ALL_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (op == CMD_PRE && all) |=> (open_vec == '0)); // R7

    AST_RD_KEEPS_BANKS: assert property (@(posedge clk) disable iff (rst)
        (op == CMD_RD || op == CMD_WR || op == CMD_NONE) |=> $stable(open_vec)); // R6

endmodule

// File: rtl/mode_regs.sv
module mode_regs
    import ddr_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [MR_AW-1:0] addr,
    input  logic [MR_DW-1:0] wr_data,
    output logic [MR_DW-1:0] rd_data
);
    logic [MR_DW-1:0]            wr_q [1:MR_NUM-1];
    logic [MR_DW*(MR_NUM-1)-1:0] wr_flat;

    for (genvar g = 1; g < MR_NUM; g++) begin : g_mr
        always_ff @(posedge clk) begin
            if (rst) begin
                wr_q[g] <= '0;
            end else if (wr_en && addr == MR_AW'(g)) begin
                wr_q[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (addr == '0) begin
            rd_data = MR_ID;
        end
        for (int i = 1; i < MR_NUM; i++) begin
            wr_flat[(i-1)*MR_DW +: MR_DW] = wr_q[i];
            if (addr == MR_AW'(i)) begin
                rd_data = wr_q[i];
            end
        end
    end

    AST_MR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || addr == '0 || int'(addr) >= MR_NUM) |=> $stable(wr_flat)); // R10

endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
    import ddr_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic [CA_W-1:0]   ca,
    output logic              cmd_vld,
    output logic [3:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic [MR_DW-1:0]  cmd_mrd,
    output logic              seq_err
);
    cap_t             cap;
    dec_t             dec;
    logic             q_open;
    logic [ROW_W-1:0] q_row;
    logic             viol;
    cmd_e             op_go;
    logic [MR_DW-1:0] mr_rd;

    ca_capture u_cap (
        .clk (clk),
        .rst (rst),
        .cke (cke),
        .ca  (ca),
        .cap (cap)
    );

    assign dec = decode_word(cap);

    always_comb begin
        viol  = ((dec.op == CMD_RD || dec.op == CMD_WR) && !q_open) ||
                (dec.op == CMD_ACT && q_open);
        op_go = viol ? CMD_NONE : dec.op;
    end

    bank_table u_banks (
        .clk    (clk),
        .rst    (rst),
        .op     (op_go),
        .bank   (dec.bank),
        .all    (dec.all),
        .row    (dec.row),
        .q_open (q_open),
        .q_row  (q_row)
    );

    mode_regs u_mr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (op_go == CMD_MRW),
        .addr    (dec.ma),
        .wr_data (dec.md),
        .rd_data (mr_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_vld  <= 1'b0;
            cmd_op   <= CMD_NONE;
            cmd_bank <= '0;
            cmd_row  <= '0;
            cmd_col  <= '0;
            cmd_mrd  <= '0;
            seq_err  <= 1'b0;
        end else begin
            cmd_vld  <= (op_go != CMD_NONE);
            cmd_op   <= op_go;
            cmd_bank <= dec.bank;
            cmd_row  <= (dec.op == CMD_ACT) ? dec.row : q_row;
            cmd_col  <= dec.col;
            cmd_mrd  <= (op_go == CMD_MRR) ? mr_rd : '0;
            seq_err  <= viol;
        end
    end

    AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        seq_err |-> !cmd_vld); // R6

    AST_PD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cap.live && !cap.cke && !cap.cke_prev) |=> (!cmd_vld && !seq_err)); // R8

    AST_CLOSED_READ_ERR: assert property (@(posedge clk) disable iff (rst)
        ((dec.op == CMD_RD || dec.op == CMD_WR) && !q_open) |=> (seq_err && !cmd_vld)); // R6

endmodule

// File: tb/sim_ddr_cmd_tracker.sv
module sim_ddr_cmd_tracker;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cke = 1'b1;
    logic [9:0] ca  = '0;

    logic        cmd_vld;
    logic [3:0]  cmd_op;
    logic [2:0]  cmd_bank;
    logic [13:0] cmd_row;
    logic [9:0]  cmd_col;
    logic [7:0]  cmd_mrd;
    logic        seq_err;

    always #4 clk = ~clk;

    ddr_cmd_tracker u0 (
        .clk(clk), .rst(rst), .cke(cke), .ca(ca),
        .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_mrd(cmd_mrd),
        .seq_err(seq_err)
    );

    int checks = 0;
    int errors = 0;

    // Reference model state
    bit          m_open [8];
    logic [13:0] m_row  [8];
    logic [7:0]  m_mr   [4];
    bit          m_ckep = 1'b1;

    // Expectation for the command currently on the outputs
    bit          e_vld = 0, e_err = 0;
    int          e_op = 0;
    logic [2:0]  e_bank = 0;
    logic [13:0] e_row = 0;
    logic [9:0]  e_col = 0;
    logic [7:0]  e_mrd = 0;
    string       e_tag = "R1";

    task automatic compare();
        bit bad;
        bad = (cmd_vld !== e_vld) || (seq_err !== e_err);
        if (e_vld && !bad) begin
            if (int'(cmd_op) != e_op) bad = 1;
            if (e_op inside {1, 2, 3, 4} && cmd_bank !== e_bank) bad = 1;
            if (e_op inside {1, 2, 3} && cmd_row !== e_row) bad = 1;
            if (e_op inside {2, 3} && cmd_col !== e_col) bad = 1;
            if (e_op == 6 && cmd_mrd !== e_mrd) bad = 1;
        end
        checks++;
        if (bad) begin
            errors++;
            $display("FAIL %s: actual vld=%0b err=%0b op=%0d bank=%0d row=%h col=%h mrd=%h expected vld=%0b err=%0b op=%0d bank=%0d row=%h col=%h mrd=%h",
                     e_tag, cmd_vld, seq_err, cmd_op, cmd_bank, cmd_row, cmd_col, cmd_mrd,
                     e_vld, e_err, e_op, e_bank, e_row, e_col, e_mrd);
        end
    endtask

    task automatic model(input bit r, input bit k, input logic [9:0] hi,
                         input logic [9:0] lo, input string tag);
        int op;
        int b;
        e_vld = 0; e_err = 0; e_op = 0; e_tag = tag;
        e_bank = hi[6:4]; e_col = {lo[9:1], 1'b0}; e_row = 0; e_mrd = 0;
        if (r) begin
            for (int i = 0; i < 8; i++) begin m_open[i] = 0; m_row[i] = 0; end
            for (int i = 0; i < 4; i++) m_mr[i] = 0;
            m_ckep = 1;
            return;
        end
        b  = int'(hi[6:4]);
        op = int'(hi[9:7]);
        if (m_ckep && !k) begin
            e_vld = 1; e_op = 8;
        end else if (!m_ckep && k) begin
            e_vld = 1; e_op = 9;
        end else if (k) begin
            case (op)
                1: if (m_open[b]) e_err = 1;
                   else begin
                       m_open[b] = 1; m_row[b] = {hi[3:0], lo};
                       e_vld = 1; e_op = 1; e_row = m_row[b];
                   end
                2, 3: if (!m_open[b]) e_err = 1;
                      else begin e_vld = 1; e_op = op; e_row = m_row[b]; end
                4: begin
                       e_vld = 1; e_op = 4;
                       if (hi[3]) for (int i = 0; i < 8; i++) m_open[i] = 0;
                       else m_open[b] = 0;
                   end
                5: begin
                       e_vld = 1; e_op = 5;
                       if (hi[6:0] >= 1 && hi[6:0] <= 3) m_mr[hi[1:0]] = lo[7:0];
                   end
                6: begin
                       e_vld = 1; e_op = 6;
                       if (hi[6:0] == 0) e_mrd = 8'h5A;
                       else if (hi[6:0] <= 3) e_mrd = m_mr[hi[1:0]];
                       else e_mrd = 0;
                   end
                default: ;
            endcase
        end
        m_ckep = k;
    endtask

    // One command cycle: upper half before the rising edge, lower half after it.
    task automatic cyc(input bit r, input bit k, input logic [9:0] hi,
                       input logic [9:0] lo, input string tag);
        rst = r; cke = k; ca = hi;
        @(posedge clk); #2;
        ca = lo;
        if (r) begin
            e_vld = 0; e_err = 0; e_tag = tag;
        end
        compare();
        model(r, k, hi, lo, tag);
        @(negedge clk); #1;
    endtask

    function automatic logic [9:0] up(input int op, input int bank, input int low4);
        return {3'(op), 3'(bank), 4'(low4)};
    endfunction

    initial begin
        #(200000 * 8);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed;
        @(negedge clk); #1;
        // R1: reset state
        repeat (3) cyc(1, 1, 0, 0, "R1");
        cyc(0, 1, up(2, 2, 0), 10'h010, "R1");            // read right after reset
        cyc(0, 1, up(0, 0, 0), 0, "R11");
        cyc(0, 1, up(7, 3, 15), 10'h3FF, "R11");          // reserved
        cyc(0, 1, up(1, 2, 4'hA), 10'h2BC, "R2");         // ACT bank2 row 2ABC
        cyc(0, 1, up(1, 2, 4'h1), 10'h001, "R4");         // ACT to open bank
        cyc(0, 1, up(2, 2, 0), 10'h3FF, "R5");            // col 3FE
        cyc(0, 1, up(3, 2, 0), 10'h155, "R5");            // col 154
        cyc(0, 1, up(1, 5, 0), 10'h001, "R4");
        cyc(0, 1, up(1, 7, 15), 10'h3FF, "R4");
        cyc(0, 1, up(3, 3, 0), 10'h020, "R6");            // closed bank
        cyc(0, 1, up(2, 3, 0), 10'h020, "R6");            // back-to-back error
        cyc(0, 1, up(2, 7, 0), 10'h0C1, "R5");
        cyc(0, 1, up(4, 2, 0), 0, "R7");                  // close bank2
        cyc(0, 1, up(2, 2, 0), 10'h004, "R7");
        cyc(0, 1, up(2, 5, 0), 10'h004, "R7");
        cyc(0, 1, up(4, 0, 8), 0, "R7");                  // all-bank close
        cyc(0, 1, up(2, 7, 0), 10'h008, "R7");
        cyc(0, 1, up(3, 5, 0), 10'h008, "R7");
        cyc(0, 1, up(1, 1, 3), 10'h133, "R4");
        cyc(0, 0, up(2, 1, 0), 10'h100, "R8");            // entry, CA ignored
        cyc(0, 0, up(1, 4, 2), 10'h222, "R8");
        cyc(0, 0, up(4, 1, 8), 10'h000, "R8");
        cyc(0, 1, up(1, 4, 2), 10'h222, "R8");            // exit, CA ignored
        cyc(0, 1, up(2, 1, 0), 10'h07E, "R8");            // bank1 kept open
        cyc(0, 1, up(2, 4, 0), 10'h07E, "R8");            // bank4 never opened
        cyc(0, 1, up(6, 0, 0), 0, "R10");
        cyc(0, 1, up(5, 0, 0), 10'h000, "R10");
        cyc(0, 1, up(6, 0, 0), 0, "R10");
        cyc(0, 1, up(5, 0, 2), 10'h0C3, "R9");
        cyc(0, 1, up(6, 0, 2), 0, "R9");
        cyc(0, 1, up(5, 0, 1), 10'h011, "R9");
        cyc(0, 1, up(6, 0, 1), 0, "R9");
        cyc(0, 1, up(5, 0, 9), 10'h077, "R10");
        cyc(0, 1, up(6, 0, 9), 0, "R10");
        cyc(0, 1, up(6, 0, 2), 0, "R10");
        // R3: pseudo-random mix, reset in the middle
        seed = 32'h1234_5678;
        for (int n = 0; n < 600; n++) begin
            logic [9:0] h, l;
            bit kk;
            seed = seed * 1103515245 + 12345;
            h = seed[25:16];
            seed = seed * 1103515245 + 12345;
            l = seed[25:16];
            kk = (seed[30:28] != 0);
            if (h[9:7] == 5) h[6:3] = 0;
            cyc((n >= 300 && n < 302), kk, h, l, (n >= 300 && n < 306) ? "R1" : "R3");
        end
        cyc(0, 1, 0, 0, "R11");
        cyc(0, 1, 0, 0, "R11");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule